// File: doc/BRIEF.md
# NAND Prefetch and Write-Posting Byte Queue

This block sits between a host or DMA port and the byte-wide data port of a NAND device and moves a programmed number of bytes in either direction through one shared 64-byte queue. A start pulse supplies a chip select, a byte count, a direction and a DMA-mode flag. For a read the engine pulls bytes from the NAND into the queue as long as there is room. The host then takes them out four at a time as 32-bit words. For a write the host posts 16-bit halfwords into the queue, and the engine drains them to the NAND one byte per cycle whenever the device signals ready.

A packed status word tells software how much it can move on its next poll and how much of the transfer is left. In DMA mode a level request tells a DMA engine when one 64-byte frame (or the final partial frame) can be moved in one burst. A stop pulse aborts and empties everything. Command and address cycles and NAND signal timing are handled elsewhere. The NAND side here is a plain strobe plus ready data path.

Top module: `nand_pfq`

## Requirements
- R1: After reset the engine is idle: `busy`=0, `status`=0, `dma_req`=0 and `nand_strobe`=0, even with `nand_ready` high.
- R2: A `start` pulse while idle is accepted at the next edge. The queue is emptied, the remaining count is loaded with `start_len`, `active_cs` takes `start_cs`, and `busy` goes to 1 unless `start_len` is 0. `start_dir` 0 means read and 1 means write. `start_nack` stays 0.
- R3: A `start` pulse while `busy` is 1 raises `start_nack` in the same cycle and changes neither the direction, the chip select, the remaining count nor the queue.
- R4: In a read, `nand_strobe` is high in a cycle only when the queue holds fewer than 64 bytes, the remaining count is non-zero and `nand_ready` is 1. The byte on `nand_rdata` is queued at that edge and the remaining count drops by one.
- R5: `status` bits 30:24 hold the queued byte count in read mode and the free space (64 minus queued bytes) in write mode. Bits 13:0 hold the remaining count. All other bits are 0.
- R6: In read mode, `host_rdata` shows the four oldest queued bytes with the oldest in bits 7:0. `host_rd` removes four bytes when at least four are queued. When fewer than four are queued and the remaining count is 0, it removes all of them and the missing upper bytes read as 0. Otherwise it is ignored.
- R7: In a write, `host_wr` posts `host_wdata` bits 7:0 first and then bits 15:8. Only bits 7:0 are posted when a single byte of the transfer is still unposted. The write is ignored when no bytes are unposted or when the free space is too small.
- R8: In a write, `nand_strobe` is high whenever the queue is non-empty and `nand_ready` is 1. `nand_wdata` carries the oldest queued byte, which is removed at that edge, and the remaining count drops by one.
- R9: `busy` falls at the edge where the remaining count reaches 0. In write mode the queue is then empty.
- R10: With DMA mode in a read, `dma_req` is high while at least 64 bytes are queued, or while the remaining count is 0 and some bytes are still queued.
- R11: With DMA mode in a busy write, `dma_req` is high while unposted bytes remain and the free space is at least 64 or at least the number of unposted bytes.
- R12: A `stop` pulse overrides `start`. At the next edge it clears `busy`, the remaining count, the queue, DMA mode and the direction (back to read).
- R13: The queue never overflows or underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| start_cs | input | 3 | Chip select for the transfer |
| start_dma | input | 1 | DMA-mode flag |
| start_dir | input | 1 | 0 read, 1 write |
| start_len | input | 14 | Transfer length in bytes |
| stop | input | 1 | Abort and empty the engine |
| start_nack | output | 1 | Start refused because the engine is busy |
| busy | output | 1 | Transfer in progress |
| active_cs | output | 3 | Chip select of the current transfer |
| status | output | 32 | Packed queue count and remaining count |
| dma_req | output | 1 | Frame request to a DMA engine |
| host_rd | input | 1 | Take one word from the queue |
| host_rdata | output | 32 | Oldest four queued bytes |
| host_wr | input | 1 | Post one halfword |
| host_wdata | input | 16 | Halfword to post |
| nand_ready | input | 1 | NAND side can move a byte |
| nand_strobe | output | 1 | A byte moves at this edge |
| nand_rdata | input | 8 | Byte from the NAND |
| nand_wdata | output | 8 | Byte to the NAND |

## Verification
Outputs fall into two groups. `start_nack`, `nand_strobe`, `host_rdata` and `dma_req` are combinational, so they are valid in the same cycle as the input or state that causes them. `busy`, `active_cs` and `status` are registered, so they change at the first edge after the stimulus. With `nand_ready` held high, a read of N bytes fetches at the N edges that follow the accepting edge, so its status is due N+1 edges after start. The bench drives inputs and samples on the falling edge. It checks registered results at the falling edge that follows the edge counted out above, and checks combinational results 1 ns after it drives the inputs, before the next rising edge.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
   typedef enum logic {
      DIR_READ  = 1'b0,
      DIR_WRITE = 1'b1
   } xfer_dir_e;
   localparam int STAT_CNT_LSB = 24;
   localparam int STAT_CNT_MAX = 7;
   localparam int STAT_REM_MAX = 14;
endpackage

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo #(
   parameter int DEPTH    = 64,
   parameter int PUSH_MAX = 2,
   parameter int POP_MAX  = 4,
   localparam int AW      = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int PN_W    = $clog2(PUSH_MAX + 1),
   localparam int QN_W    = $clog2(POP_MAX + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic [PN_W-1:0]       push_n,
   input  logic [PUSH_MAX*8-1:0] push_data,
   input  logic [QN_W-1:0]       pop_n,
   output logic [POP_MAX*8-1:0]  head_data,
   output logic [CNT_W-1:0]      count
);
   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;

   always_ff @(posedge clk) begin
      for (int i = 0; i < PUSH_MAX; i++) begin
         if (!clear && PN_W'(i) < push_n)
            mem[wr_ptr + AW'(i)] <= push_data[i*8 +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         wr_ptr <= wr_ptr + AW'(push_n);
         rd_ptr <= rd_ptr + AW'(pop_n);
         count  <= count + CNT_W'(push_n) - CNT_W'(pop_n);
      end
   end

   always_comb begin
      for (int i = 0; i < POP_MAX; i++)
         head_data[i*8 +: 8] = (CNT_W'(i) < count) ? mem[rd_ptr + AW'(i)] : 8'h00;
   end

   // R13: pushes fit the space left, pops never exceed the content
   assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |-> (32'(count) + 32'(push_n) <= DEPTH + 32'(pop_n)));
   assert_no_underflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |-> (32'(pop_n) <= 32'(count)));
endmodule

// File: rtl/pfq_engine.sv
module pfq_engine
   import pfq_pkg::*;
#(
   parameter int DEPTH    = 64,
   parameter int LEN_W    = 14,
   parameter int CS_W     = 3,
   parameter int RD_BYTES = 4,
   parameter int WR_BYTES = 2,
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int PN_W    = $clog2(WR_BYTES + 1),
   localparam int QN_W    = $clog2(RD_BYTES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [CS_W-1:0]       start_cs,
   input  logic                  start_dma,
   input  logic                  start_dir,
   input  logic [LEN_W-1:0]      start_len,
   input  logic                  stop,
   output logic                  start_nack,
   output logic                  run,
   output logic                  wr_mode,
   output logic                  dma_mode,
   output logic [CS_W-1:0]       cs,
   output logic [LEN_W-1:0]      rem,
   output logic [31:0]           status,
   input  logic [CNT_W-1:0]      fifo_count,
   output logic                  fifo_clear,
   output logic [PN_W-1:0]       push_n,
   output logic [WR_BYTES*8-1:0] push_data,
   output logic [QN_W-1:0]       pop_n,
   input  logic                  host_rd,
   input  logic                  host_wr,
   input  logic [WR_BYTES*8-1:0] host_wdata,
   input  logic                  nand_ready,
   input  logic [7:0]            nand_rdata,
   output logic                  nand_strobe
);
   xfer_dir_e        dir_q;
   logic             run_q, dma_q;
   logic [CS_W-1:0]  cs_q;
   logic [LEN_W-1:0] rem_q, rem_nxt, host_left;
   logic [CNT_W-1:0] free;
   logic             start_ok, fetch, drain, wr_ok;
   logic [PN_W-1:0]  wr_n;
   logic [QN_W-1:0]  rd_n;

   assign start_ok   = start && !run_q && !stop;
   assign start_nack = start && run_q;
   assign fifo_clear = start_ok || stop;
   assign free       = CNT_W'(DEPTH) - fifo_count;
   assign host_left  = rem_q - LEN_W'(fifo_count);

   assign fetch = run_q && dir_q == DIR_READ && rem_q != '0
                  && fifo_count < CNT_W'(DEPTH) && nand_ready;
   assign drain = run_q && dir_q == DIR_WRITE && fifo_count != '0 && nand_ready;
   assign nand_strobe = fetch || drain;
   assign rem_nxt = rem_q - LEN_W'(nand_strobe);

   always_comb begin
      if (host_left >= LEN_W'(WR_BYTES)) wr_n = PN_W'(WR_BYTES);
      else                               wr_n = PN_W'(host_left);
      wr_ok = run_q && dir_q == DIR_WRITE && host_wr && wr_n != '0
              && free >= CNT_W'(wr_n);
      if (fifo_count >= CNT_W'(RD_BYTES)) rd_n = QN_W'(RD_BYTES);
      else if (rem_q == '0)               rd_n = QN_W'(fifo_count);
      else                                rd_n = '0;
   end

   always_comb begin
      push_n    = fetch ? PN_W'(1) : (wr_ok ? wr_n : '0);
      push_data = fetch ? {{(WR_BYTES*8-8){1'b0}}, nand_rdata} : host_wdata;
      pop_n     = drain ? QN_W'(1)
                : ((dir_q == DIR_READ && host_rd) ? rd_n : '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || stop) begin
         run_q <= 1'b0;
         dir_q <= DIR_READ;
         dma_q <= 1'b0;
         rem_q <= '0;
         if (!rst_n) cs_q <= '0;
      end else if (start_ok) begin
         run_q <= start_len != '0;
         dir_q <= xfer_dir_e'(start_dir);
         dma_q <= start_dma;
         cs_q  <= start_cs;
         rem_q <= start_len;
      end else begin
         rem_q <= rem_nxt;
         if (rem_nxt == '0) run_q <= 1'b0;
      end
   end

   always_comb begin
      status = '0;
      status[STAT_CNT_LSB +: CNT_W] = (dir_q == DIR_READ) ? fifo_count : free;
      status[0 +: LEN_W] = rem_q;
   end

   assign run      = run_q;
   assign wr_mode  = dir_q == DIR_WRITE;
   assign dma_mode = dma_q;
   assign cs       = cs_q;
   assign rem      = rem_q;

   // R4 / R8: each strobe moves exactly one byte of the count
   assert_rem_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !stop && !start) |=> rem_q == $past(rem_q) - LEN_W'($past(nand_strobe)));
   // R3: a refused start leaves the transfer untouched
   assert_nack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && run_q && !stop) |=> (dir_q == $past(dir_q) && cs_q == $past(cs_q)));
   // R9: busy implies work left; an idle write leaves nothing queued
   assert_busy_rem_R9: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> rem_q != '0);
   assert_write_done_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && dir_q == DIR_WRITE) |-> fifo_count == '0);
   // R12: stop clears the engine at the next edge
   assert_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (!run_q && rem_q == '0 && !dma_q));
endmodule

// File: rtl/pfq_dma_req.sv
module pfq_dma_req #(
   parameter bit DMA_EN = 1'b1,
   parameter int DEPTH  = 64,
   parameter int FRAME  = 64,
   parameter int LEN_W  = 14,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dma_mode,
   input  logic             wr_mode,
   input  logic             run,
   input  logic [LEN_W-1:0] rem,
   input  logic [CNT_W-1:0] count,
   output logic             req
);
   if (DMA_EN) begin : g_dma
      logic [CNT_W-1:0] free;
      logic [LEN_W-1:0] host_left;
      logic             rd_req, wr_req;
      assign free      = CNT_W'(DEPTH) - count;
      assign host_left = rem - LEN_W'(count);
      assign rd_req = !wr_mode && (count >= CNT_W'(FRAME) || (rem == '0 && count != '0));
      assign wr_req = wr_mode && run && host_left != '0
                      && (free >= CNT_W'(FRAME) || LEN_W'(free) >= host_left);
      assign req = dma_mode && (rd_req || wr_req);

      // R10: requests only in DMA mode
      assert_req_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
         req |-> dma_mode);
      // R11: write requests only while the transfer runs
      assert_wr_req_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (req && wr_mode) |-> run);
   end else begin : g_no_dma
      assign req = 1'b0;
   end
endmodule

// File: rtl/nand_pfq.sv
module nand_pfq #(
   parameter int DEPTH    = 64,
   parameter int FRAME    = 64,
   parameter int LEN_W    = 14,
   parameter int CS_W     = 3,
   parameter int RD_BYTES = 4,
   parameter int WR_BYTES = 2,
   parameter bit DMA_EN   = 1'b1,
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int PN_W    = $clog2(WR_BYTES + 1),
   localparam int QN_W    = $clog2(RD_BYTES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [CS_W-1:0]       start_cs,
   input  logic                  start_dma,
   input  logic                  start_dir,
   input  logic [LEN_W-1:0]      start_len,
   input  logic                  stop,
   output logic                  start_nack,
   output logic                  busy,
   output logic [CS_W-1:0]       active_cs,
   output logic [31:0]           status,
   output logic                  dma_req,
   input  logic                  host_rd,
   output logic [RD_BYTES*8-1:0] host_rdata,
   input  logic                  host_wr,
   input  logic [WR_BYTES*8-1:0] host_wdata,
   input  logic                  nand_ready,
   output logic                  nand_strobe,
   input  logic [7:0]            nand_rdata,
   output logic [7:0]            nand_wdata
);
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("nand_pfq: DEPTH must be a power of two");
   end
   if (FRAME > DEPTH || FRAME < 1) begin : g_bad_frame
      $error("nand_pfq: FRAME must lie in 1..DEPTH");
   end
   if (CNT_W > pfq_pkg::STAT_CNT_MAX || LEN_W > pfq_pkg::STAT_REM_MAX || LEN_W < CNT_W) begin : g_bad_stat
      $error("nand_pfq: count fields do not fit the status word");
   end
   if (RD_BYTES > DEPTH || WR_BYTES > DEPTH || WR_BYTES < 1) begin : g_bad_port
      $error("nand_pfq: host port widths exceed the queue");
   end

   logic                  fifo_clear, run, wr_mode, dma_mode;
   logic [CNT_W-1:0]      fifo_count;
   logic [PN_W-1:0]       push_n;
   logic [WR_BYTES*8-1:0] push_data;
   logic [QN_W-1:0]       pop_n;
   logic [LEN_W-1:0]      rem;

   pfq_byte_fifo #(.DEPTH(DEPTH), .PUSH_MAX(WR_BYTES), .POP_MAX(RD_BYTES)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clear(fifo_clear),
      .push_n(push_n), .push_data(push_data), .pop_n(pop_n),
      .head_data(host_rdata), .count(fifo_count)
   );

   pfq_engine #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CS_W(CS_W),
                .RD_BYTES(RD_BYTES), .WR_BYTES(WR_BYTES)) u_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .start_cs(start_cs),
      .start_dma(start_dma), .start_dir(start_dir), .start_len(start_len),
      .stop(stop), .start_nack(start_nack), .run(run), .wr_mode(wr_mode),
      .dma_mode(dma_mode), .cs(active_cs), .rem(rem), .status(status),
      .fifo_count(fifo_count), .fifo_clear(fifo_clear), .push_n(push_n),
      .push_data(push_data), .pop_n(pop_n), .host_rd(host_rd),
      .host_wr(host_wr), .host_wdata(host_wdata), .nand_ready(nand_ready),
      .nand_rdata(nand_rdata), .nand_strobe(nand_strobe)
   );

   pfq_dma_req #(.DMA_EN(DMA_EN), .DEPTH(DEPTH), .FRAME(FRAME), .LEN_W(LEN_W)) u_dma (
      .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .wr_mode(wr_mode),
      .run(run), .rem(rem), .count(fifo_count), .req(dma_req)
   );

   assign busy       = run;
   assign nand_wdata = host_rdata[7:0];
endmodule

// File: tb/nand_pfq_test.sv
`timescale 1ns/1ps
module nand_pfq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, start_dma = 1'b0, start_dir = 1'b0, stop = 1'b0;
   logic [2:0]  start_cs = '0;
   logic [13:0] start_len = '0;
   logic        start_nack, busy, dma_req, nand_strobe;
   logic [2:0]  active_cs;
   logic [31:0] status, host_rdata;
   logic        host_rd = 1'b0, host_wr = 1'b0, nand_ready = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [7:0]  nand_rdata, nand_wdata;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   logic       mode_wr = 1'b0, model_clr = 1'b0;
   logic [7:0] rd_idx;
   logic [7:0] wcap [0:255];
   int         wcnt;

   always #4 clk = ~clk;

   nand_pfq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_cs(start_cs),
      .start_dma(start_dma), .start_dir(start_dir), .start_len(start_len),
      .stop(stop), .start_nack(start_nack), .busy(busy), .active_cs(active_cs),
      .status(status), .dma_req(dma_req), .host_rd(host_rd),
      .host_rdata(host_rdata), .host_wr(host_wr), .host_wdata(host_wdata),
      .nand_ready(nand_ready), .nand_strobe(nand_strobe),
      .nand_rdata(nand_rdata), .nand_wdata(nand_wdata)
   );

   // NAND device model: read bytes 0x30, 0x31, ...; write bytes captured in order
   assign nand_rdata = 8'h30 + rd_idx;
   always @(posedge clk) begin
      if (model_clr) begin
         rd_idx <= 8'h00;
         wcnt   <= 0;
      end else if (nand_strobe) begin
         if (mode_wr) begin
            wcap[wcnt[7:0]] <= nand_wdata;
            wcnt <= wcnt + 1;
         end else begin
            rd_idx <= rd_idx + 8'h01;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic model_reset(input logic wr);
      mode_wr = wr;
      model_clr = 1'b1;
      @(negedge clk);
      model_clr = 1'b0;
   endtask

   task automatic do_start(input logic dir, input logic dma, input int len, input int cs);
      start = 1'b1; start_dir = dir; start_dma = dma;
      start_len = 14'(len); start_cs = 3'(cs);
      #1 chk("R2 no nack when idle", {31'd0, start_nack}, 32'd0);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic pulse_stop();
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
   endtask

   task automatic hread(output logic [31:0] d);
      host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic hwrite(input logic [15:0] v);
      host_wr = 1'b1; host_wdata = v;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic t_reset();
      nand_ready = 1'b1;
      cyc(2);
      chk("R1 busy", {31'd0, busy}, 32'd0);
      chk("R1 status", status, 32'd0);
      chk("R1 dma_req", {31'd0, dma_req}, 32'd0);
      chk("R1 strobe", {31'd0, nand_strobe}, 32'd0);
   endtask

   task automatic t_read_short();
      logic [31:0] d;
      model_reset(1'b0);
      nand_ready = 1'b1;
      do_start(1'b0, 1'b0, 10, 5);
      chk("R2 busy", {31'd0, busy}, 32'd1);
      chk("R2 cs", {29'd0, active_cs}, 32'd5);
      chk("R5 status start", status, 32'h0000000A);
      cyc(4);
      chk("R4 R5 mid read", status, 32'h04000006);
      cyc(6);
      chk("R9 read done busy", {31'd0, busy}, 32'd0);
      chk("R4 read done", status, 32'h0A000000);
      hread(d); chk("R6 word0", d, 32'h33323130);
      hread(d); chk("R6 word1", d, 32'h37363534);
      hread(d); chk("R6 tail pad", d, 32'h00003938);
      chk("R6 tail emptied", status, 32'h00000000);
   endtask

   task automatic t_backpressure();
      logic [31:0] d;
      model_reset(1'b0);
      nand_ready = 1'b1;
      do_start(1'b0, 1'b0, 70, 1);
      cyc(80);
      chk("R4 full stops", status, 32'h40000006);
      #1 chk("R4 no strobe when full", {31'd0, nand_strobe}, 32'd0);
      hread(d); chk("R6 word under full", d, 32'h33323130);
      host_rd = 1'b1;
      host_wr = 1'b0;
      host_rd = 1'b0;
      cyc(9);
      chk("R4 refill", status, 32'h40000002);
      host_rd = 1'b1; #1;
      host_rd = 1'b0;
      pulse_stop();
      chk("R12 stop busy", {31'd0, busy}, 32'd0);
      chk("R12 stop status", status, 32'd0);
   endtask

   task automatic t_refuse();
      model_reset(1'b0);
      nand_ready = 1'b0;
      do_start(1'b0, 1'b0, 20, 3);
      chk("R2 read start", status, 32'h00000014);
      start = 1'b1; start_dir = 1'b1; start_len = 14'd5; start_cs = 3'd6;
      #1 chk("R3 nack", {31'd0, start_nack}, 32'd1);
      @(negedge clk);
      start = 1'b0;
      chk("R3 status kept", status, 32'h00000014);
      chk("R3 cs kept", {29'd0, active_cs}, 32'd3);
      #1 chk("R4 ready low no strobe", {31'd0, nand_strobe}, 32'd0);
      cyc(3);
      chk("R4 ready low holds", status, 32'h00000014);
      pulse_stop();
   endtask

   task automatic t_write_basic();
      model_reset(1'b1);
      nand_ready = 1'b0;
      do_start(1'b1, 1'b0, 6, 0);
      chk("R5 write status", status, 32'h40000006);
      hwrite(16'h2211); hwrite(16'h4433); hwrite(16'h6655);
      chk("R7 posted", status, 32'h3A000006);
      hwrite(16'h8877);
      chk("R7 extra ignored", status, 32'h3A000006);
      nand_ready = 1'b1;
      cyc(6);
      chk("R9 write done busy", {31'd0, busy}, 32'd0);
      chk("R8 write drained", status, 32'h40000000);
      chk("R8 byte count", wcnt, 32'd6);
      for (int i = 0; i < 6; i++)
         chk("R8 byte order", {24'd0, wcap[i]}, 32'h11 * (i + 1));
      nand_ready = 1'b0;
   endtask

   task automatic t_write_odd();
      model_reset(1'b1);
      nand_ready = 1'b0;
      do_start(1'b1, 1'b0, 3, 0);
      hwrite(16'hBBAA); hwrite(16'hDDCC);
      chk("R7 last single byte", status, 32'h3D000003);
      hwrite(16'hFFEE);
      chk("R7 none left ignored", status, 32'h3D000003);
      nand_ready = 1'b1;
      cyc(3);
      chk("R8 odd drained", status, 32'h40000000);
      chk("R8 odd b0", {24'd0, wcap[0]}, 32'hAA);
      chk("R8 odd b1", {24'd0, wcap[1]}, 32'hBB);
      chk("R8 odd b2", {24'd0, wcap[2]}, 32'hCC);
      nand_ready = 1'b0;
   endtask

   task automatic t_write_full();
      model_reset(1'b1);
      nand_ready = 1'b0;
      do_start(1'b1, 1'b0, 100, 2);
      for (int i = 0; i < 32; i++) hwrite(16'(i));
      chk("R7 queue full", status, 32'h00000064);
      hwrite(16'hABCD);
      chk("R7 R13 full ignored", status, 32'h00000064);
      chk("R11 no dma req off", {31'd0, dma_req}, 32'd0);
      pulse_stop();
   endtask

   task automatic t_dma_read();
      logic [31:0] d;
      model_reset(1'b0);
      nand_ready = 1'b1;
      do_start(1'b0, 1'b1, 80, 0);
      chk("R10 no req empty", {31'd0, dma_req}, 32'd0);
      cyc(64);
      chk("R10 frame status", status, 32'h40000010);
      chk("R10 frame req", {31'd0, dma_req}, 32'd1);
      hread(d); chk("R6 dma word0", d, 32'h33323130);
      for (int i = 1; i < 16; i++) hread(d);
      chk("R10 after frame", status, 32'h0F000001);
      chk("R10 req low", {31'd0, dma_req}, 32'd0);
      cyc(5);
      chk("R10 tail status", status, 32'h10000000);
      chk("R10 tail req", {31'd0, dma_req}, 32'd1);
      for (int i = 0; i < 4; i++) hread(d);
      chk("R10 tail taken", {31'd0, dma_req}, 32'd0);
      pulse_stop();
   endtask

   task automatic t_dma_write();
      model_reset(1'b1);
      nand_ready = 1'b0;
      do_start(1'b1, 1'b1, 6, 0);
      chk("R11 short req", {31'd0, dma_req}, 32'd1);
      hwrite(16'h0102); hwrite(16'h0304); hwrite(16'h0506);
      chk("R11 all posted", {31'd0, dma_req}, 32'd0);
      pulse_stop();
      chk("R12 stop req", {31'd0, dma_req}, 32'd0);
      do_start(1'b1, 1'b1, 200, 0);
      chk("R11 long req", {31'd0, dma_req}, 32'd1);
      hwrite(16'h0708);
      chk("R11 frame space gone", {31'd0, dma_req}, 32'd0);
      pulse_stop();
   endtask

   task automatic t_len_zero();
      do_start(1'b0, 1'b0, 0, 4);
      chk("R2 zero length busy", {31'd0, busy}, 32'd0);
      chk("R2 zero length status", status, 32'd0);
      do_start(1'b0, 1'b0, 4, 4);
      chk("R2 restart", {31'd0, busy}, 32'd1);
      pulse_stop();
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      t_reset();
      t_read_short();
      t_backpressure();
      t_refuse();
      t_write_basic();
      t_write_odd();
      t_write_full();
      t_dma_read();
      t_dma_write();
      t_len_zero();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule